// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Counter

A four-bit synchronous counter that moves on the rising edge of its clock. It serves as one stage of a wider counter. A build-time parameter sets the modulus: decade (0 through 9) or full binary (0 through 15). A second build-time parameter decides how the active-low clear acts. It can act at once, without any clock edge, or it can wait for the next rising edge.

The stage can be preset from a four-bit data input through an active-low synchronous load. A carry input gates counting. A carry output rises when the stage is about to roll over. To cascade stages, every stage shares the same clock, and each carry output drives the carry input of the next stage. The carry input of the least significant stage is tied high.

When the clear is synchronous, a shortened count sequence built from external decode logic must detect the value one below the intended restart point. The clear only acts on the following edge.

Top module: `sync_preset_counter`

## Requirements
- R1: With the clear high, the load high and the carry input high, each rising edge raises the count by one, as long as the count is below its terminal value.
- R2: The terminal value is 9 when MOD_DECADE is 1 and 15 when MOD_DECADE is 0. A counting edge taken at the terminal value returns the count to 0.
- R3: With MOD_DECADE = 1, a counting edge taken at any count above 9 returns the count to 0. Such a count can only come from a load.
- R4: When the load input is low and the clear is high at a rising edge, the data input is copied into the count, whatever the carry input is. Data bit 0 becomes count bit 0.
- R5: With the clear high, the load high and the carry input low, a rising edge leaves the count unchanged.
- R6: The carry output is combinational. It is 1 exactly when the carry input is 1 and the count equals the terminal value.
- R7: With CLEAR_ASYNC = 1, a low clear forces the count to 0 at once, with no clock edge needed.
- R8: With CLEAR_ASYNC = 0, a low clear leaves the count unchanged until the next rising edge, and that edge sets it to 0.
- R9: A low clear takes precedence over both load and count. Load takes precedence over count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active |
| clr_n | input | 1 | Active-low clear (immediate or edge-timed, per CLEAR_ASYNC) |
| load_n | input | 1 | Active-low synchronous preset enable |
| carry_in | input | 1 | Count enable from the previous stage (tie high on the first stage) |
| din | input | 4 | Preset value |
| q | output | 4 | Current count, bit 0 least significant |
| carry_out | output | 1 | Terminal-count flag gated by carry_in, feeds the next stage |

## Verification
The bench builds two copies side by side from the same stimulus. One is a decade stage with an immediate clear. The other is a binary stage with an edge-timed clear. Between clock edges, the first copy shows the count at zero while the second still holds its old value, which exposes the difference between R7 and R8. The decade copy makes the out-of-range loads of R3 testable. The binary copy makes the full 15-to-0 rollover and its carry testable.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

  // Last value of the counting sequence for the chosen modulus.
  function automatic logic [CNT_W-1:0] term_value(input bit decade);
    if (decade) return CNT_W'(9);
    return {CNT_W{1'b1}};
  endfunction

  // Value reached by one counting step. Decade mode folds every value
  // at or above 9 back to zero.
  function automatic logic [CNT_W-1:0] step_value(input logic [CNT_W-1:0] cur,
                                                  input bit decade);
    if (cur >= term_value(decade)) return '0;
    return cur + CNT_W'(1);
  endfunction
endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
  import cnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    carry_in,
  output cnt_op_e op
);
  // Fixed precedence: clear, then load, then count, then hold.
  always_comb begin
    if (!clr_n)       op = OP_CLEAR;
    else if (!load_n) op = OP_LOAD;
    else if (carry_in) op = OP_COUNT;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_term_detect.sv
module cnt_term_detect
  import cnt_pkg::*;
#(
  parameter bit MOD_DECADE = 1'b1
) (
  input  logic [CNT_W-1:0] q,
  input  logic             carry_in,
  output logic             at_term,
  output logic             carry_out
);
  localparam logic [CNT_W-1:0] TERM = term_value(MOD_DECADE);

  assign at_term   = (q == TERM);
  assign carry_out = carry_in & at_term;
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
  import cnt_pkg::*;
#(
  parameter bit MOD_DECADE  = 1'b1,
  parameter bit CLEAR_ASYNC = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  cnt_op_e          op,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] q
);
  logic [CNT_W-1:0] q_next;

  always_comb begin
    unique case (op)
      OP_CLEAR: q_next = '0;
      OP_LOAD:  q_next = din;
      OP_COUNT: q_next = step_value(q, MOD_DECADE);
      default:  q_next = q;
    endcase
  end

  generate
    if (CLEAR_ASYNC) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= q_next;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        q <= q_next;
      end
    end
  endgenerate
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import cnt_pkg::*;
#(
  parameter bit MOD_DECADE  = 1'b1,
  parameter bit CLEAR_ASYNC = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             carry_in,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] q,
  output logic             carry_out
);
  cnt_op_e op;
  logic    op_count;
  logic    op_load;
  logic    at_term;

  cnt_op_decode u_dec (
    .clr_n    (clr_n),
    .load_n   (load_n),
    .carry_in (carry_in),
    .op       (op)
  );

  assign op_count = (op == OP_COUNT);
  assign op_load  = (op == OP_LOAD);

  cnt_state_reg #(
    .MOD_DECADE  (MOD_DECADE),
    .CLEAR_ASYNC (CLEAR_ASYNC)
  ) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .op    (op),
    .din   (din),
    .q     (q)
  );

  cnt_term_detect #(
    .MOD_DECADE (MOD_DECADE)
  ) u_term (
    .q         (q),
    .carry_in  (carry_in),
    .at_term   (at_term),
    .carry_out (carry_out)
  );
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker
  import cnt_pkg::*;
#(
  parameter bit MOD_DECADE  = 1'b1,
  parameter bit CLEAR_ASYNC = 1'b1
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             carry_in,
  input logic [CNT_W-1:0] din,
  input logic [CNT_W-1:0] q,
  input logic             carry_out,
  input logic             op_count,
  input logic             op_load,
  input logic             at_term
);
  localparam logic [CNT_W-1:0] TERM = term_value(MOD_DECADE);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_step_r1: assert property (@(posedge clk) disable iff (!clr_n || !armed)
    (op_count && q < TERM) |=> (q == $past(q) + CNT_W'(1)));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!clr_n || !armed)
    (op_count && at_term) |=> (q == '0));

  p_load_r4: assert property (@(posedge clk) disable iff (!clr_n || !armed)
    op_load |=> (q == $past(din)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n || !armed)
    (load_n && !carry_in) |=> $stable(q));

  p_carry_r6: assert property (@(posedge clk) disable iff (!armed)
    carry_out |-> (carry_in && q == TERM));

  generate
    if (CLEAR_ASYNC) begin : g_chk_async
      p_clear_now_r7: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |-> (q == '0));
    end else begin : g_chk_sync
      p_clear_edge_r8: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (q == '0));
      p_clear_over_load_r9: assert property (@(posedge clk) disable iff (!armed)
        (!clr_n && !load_n) |=> (q == '0));
    end
  endgenerate
endmodule

bind sync_preset_counter cnt_checker #(
  .MOD_DECADE  (MOD_DECADE),
  .CLEAR_ASYNC (CLEAR_ASYNC)
) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .carry_in  (carry_in),
  .din       (din),
  .q         (q),
  .carry_out (carry_out),
  .op_count  (op_count),
  .op_load   (op_load),
  .at_term   (at_term)
);

// File: tb/sync_preset_counter_bench.sv
module sync_preset_counter_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       clr_n, load_n, ci;
  logic [3:0] din;
  wire  [3:0] q_a, q_b;
  wire        co_a, co_b;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_a, m_b;

  sync_preset_counter #(.MOD_DECADE(1'b1), .CLEAR_ASYNC(1'b1)) u_sync_preset_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .carry_in(ci), .din(din),
    .q(q_a), .carry_out(co_a));

  sync_preset_counter #(.MOD_DECADE(1'b0), .CLEAR_ASYNC(1'b0)) u_sync_preset_counter_bin (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .carry_in(ci), .din(din),
    .q(q_b), .carry_out(co_b));

  function automatic logic [3:0] ref_next(input logic [3:0] v, input bit dec);
    int lim;
    lim = dec ? 9 : 15;
    if (int'(v) >= lim) return 4'd0;
    return v + 4'd1;
  endfunction

  function automatic logic ref_carry(input logic [3:0] v, input logic c, input bit dec);
    return c && (int'(v) == (dec ? 9 : 15));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] ref_edge(input logic [3:0] v, input bit dec);
    if (!clr_n) return 4'd0;
    if (!load_n) return din;
    if (ci) return ref_next(v, dec);
    return v;
  endfunction

  // Called at a falling edge: drive, take one rising edge, check at next falling edge.
  task automatic cycle(input logic c, input logic l, input logic i, input logic [3:0] d,
                       input string tag);
    clr_n = c; load_n = l; ci = i; din = d;
    @(posedge clk);
    m_a = ref_edge(m_a, 1'b1);
    m_b = ref_edge(m_b, 1'b0);
    @(negedge clk);
    chk({tag, " decade"}, q_a, m_a);
    chk({tag, " binary"}, q_b, m_b);
    chk("R6 decade carry", co_a, ref_carry(m_a, ci, 1'b1));
    chk("R6 binary carry", co_b, ref_carry(m_b, ci, 1'b0));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clr_n = 1'b0; load_n = 1'b1; ci = 1'b0; din = 4'd0;
    #1;
    chk("R7 reset state, no edge yet", q_a, 0);
    m_a = 4'd0; m_b = 4'd0;
    @(negedge clk);
    cycle(1'b0, 1'b1, 1'b0, 4'd0, "R8 clear at edge");

    // Plain counting through both terminal values.
    for (int k = 0; k < 18; k++) cycle(1'b1, 1'b1, 1'b1, 4'd0, "R1 R2 count");

    // Hold with carry input low.
    for (int k = 0; k < 3; k++) cycle(1'b1, 1'b1, 1'b0, 4'd3, "R5 hold");

    // Loads, with and without carry input.
    cycle(1'b1, 1'b0, 1'b0, 4'd7, "R4 load ci low");
    cycle(1'b1, 1'b0, 1'b1, 4'd12, "R4 R9 load beats count");
    cycle(1'b1, 1'b1, 1'b1, 4'd0, "R3 out of range folds");
    cycle(1'b1, 1'b0, 1'b1, 4'd9, "R4 load terminal");
    chk("R6 decade carry at 9", co_a, 1);
    cycle(1'b1, 1'b0, 1'b1, 4'd15, "R4 load 15");
    chk("R6 binary carry at 15", co_b, 1);
    cycle(1'b1, 1'b1, 1'b1, 4'd0, "R2 R3 wrap from 15");

    // Clear against load.
    cycle(1'b1, 1'b0, 1'b0, 4'd5, "R4 load 5");
    cycle(1'b0, 1'b0, 1'b1, 4'd11, "R9 clear beats load");

    // Immediate versus edge-timed clear, observed between edges.
    cycle(1'b1, 1'b0, 1'b0, 4'd5, "R4 load 5 again");
    clr_n = 1'b0;
    #1;
    chk("R7 immediate clear", q_a, 0);
    chk("R8 clear waits for edge", q_b, 5);
    m_a = 4'd0;
    @(negedge clk);
    cycle(1'b0, 1'b1, 1'b1, 4'd0, "R8 clear applied");

    // Constrained random run.
    for (int k = 0; k < 800; k++) begin
      logic c, l, i;
      logic [3:0] d;
      c = ($urandom_range(15) != 0);
      l = ($urandom_range(7) != 0);
      i = ($urandom_range(3) != 0);
      d = 4'($urandom_range(15));
      cycle(c, l, i, d, "R1 R4 R5 R9 random");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule